// File: doc/BRIEF.md
# Instruction Queue Status Tracker

This block sits beside a processor that prefetches code into a 4-byte instruction queue. It keeps a shadow copy of that queue using only signals visible on the bus. A code-fetch bus cycle carries one byte on the 8-bit data bus. When the capture strobe marks such a cycle, the byte is appended to the shadow queue. A 2-bit queue-status code is sampled on every clock. It says whether the processor took the first byte of an opcode, took a later byte of the instruction, emptied its queue, or did nothing.

The processor presents the queue-status code during the clock that follows the queue operation it describes. The tracker applies each sampled code at the same edge that samples it. Its shadow state therefore runs one clock behind the processor's internal queue, with every operation in the same order. On each removal it reports, from registers, the byte taken and whether it began an instruction. It also reports the current fill level. A removal from an empty shadow queue sets a sticky error flag, which means the tracker and the processor have lost step. Decoding the instruction bytes is left to downstream logic.

Top module: `iq_shadow_tracker`

## Requirements
- R1: While reset is asserted, the fill level, the removal-valid flag, the first-byte flag, the reported byte and the error flag are all zero.
- R2: A byte is appended only at an edge where the capture strobe is high and the bus status equals 3'b100 (code access). Any other bus status, or a low strobe, leaves the fill level unchanged.
- R3: A queue status of 2'b01 (first opcode byte) or 2'b11 (subsequent byte), sampled while the shadow queue is non-empty, removes one byte. After that edge the removal-valid flag is 1, the reported byte is the removed byte, and the first-byte flag is 1 for 2'b01 and 0 for 2'b11.
- R4: Bytes are removed in the order in which they were appended.
- R5: A queue status of 2'b10 (flush) sets the fill level to 0, produces no removal report, and discards a byte captured at the same edge.
- R6: A queue status of 2'b00 produces no removal report. The reported byte keeps its last value, and the fill level changes only through an append.
- R7: When an append and a removal happen at the same edge, the fill level stays the same and FIFO order is kept. This also applies when the queue holds 4 bytes.
- R8: A removal status sampled while the shadow queue is empty produces no report and sets the error flag. The flag stays set until reset. A byte appended at that same edge is still stored.
- R9: An append at an edge where the queue already holds 4 bytes and no removal happens is dropped. The fill level stays at 4.
- R10: The fill level never exceeds the queue depth of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_stat_i | input | 3 | Bus cycle status code; 3'b100 marks a code fetch |
| fetch_stb_i | input | 1 | Capture strobe for the data byte of a bus cycle |
| fetch_data_i | input | 8 | Data bus byte |
| qstat_i | input | 2 | Queue-status code, sampled every clock |
| rm_valid_o | output | 1 | A byte was removed at the last edge |
| rm_first_o | output | 1 | The removed byte was the first byte of an opcode |
| rm_byte_o | output | 8 | Last removed byte |
| fill_o | output | 3 | Number of bytes in the shadow queue |
| underrun_o | output | 1 | Sticky flag: removal was requested from an empty queue |

## Verification
The assertions check these rules on every clock: the depth bound, the effect of a flush, the report and first-byte flag that follow each removal, the quiet behaviour under the no-operation code, a constant fill level when an append and a removal coincide, and the setting and holding of the error flag. Only the bench scenarios can show which byte comes out. That covers FIFO order across wrap-around, the byte dropped when the queue is full, the byte discarded by a flush, and the byte stored during an underrun. It also covers reset applied in the middle of operation.

// File: rtl/iqs_pkg.sv
package iqs_pkg;
  typedef enum logic [1:0] {
    QS_IDLE  = 2'b00,
    QS_FIRST = 2'b01,
    QS_FLUSH = 2'b10,
    QS_NEXT  = 2'b11
  } qstat_e;

  localparam logic [2:0] BUS_CODE_FETCH = 3'b100;
endpackage

// File: rtl/iqs_decode.sv
module iqs_decode
  import iqs_pkg::*;
(
  input  logic [2:0] bus_stat_i,
  input  logic       fetch_stb_i,
  input  logic [1:0] qstat_i,
  output logic       push_req_o,
  output logic       pop_req_o,
  output logic       pop_first_o,
  output logic       flush_o
);
  qstat_e qs;

  always_comb begin
    qs          = qstat_e'(qstat_i);
    push_req_o  = fetch_stb_i && (bus_stat_i == BUS_CODE_FETCH);
    pop_req_o   = 1'b0;
    pop_first_o = 1'b0;
    flush_o     = 1'b0;
    unique case (qs)
      QS_FIRST: begin
        pop_req_o   = 1'b1;
        pop_first_o = 1'b1;
      end
      QS_NEXT:  pop_req_o = 1'b1;
      QS_FLUSH: flush_o   = 1'b1;
      default:  ;
    endcase
  end
endmodule

// File: rtl/iqs_shadow_fifo.sv
module iqs_shadow_fifo #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_req_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_req_i,
  input  logic              flush_i,
  output logic [DATA_W-1:0] head_data_o,
  output logic              pop_ok_o,
  output logic              underrun_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d, wr_ptr_q, wr_ptr_d;
  logic [CNT_W-1:0]  count_q, count_d;
  logic [DEPTH-1:0]  wr_en;
  logic              empty, full, pop_ok, push_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    empty    = (count_q == '0);
    full     = (count_q == CNT_W'(DEPTH));
    pop_ok   = !flush_i && pop_req_i && !empty;
    push_ok  = !flush_i && push_req_i && (!full || pop_ok);
    rd_ptr_d = rd_ptr_q;
    wr_ptr_d = wr_ptr_q;
    count_d  = count_q;
    wr_en    = '0;
    if (flush_i) begin
      rd_ptr_d = '0;
      wr_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (pop_ok)  rd_ptr_d = ptr_inc(rd_ptr_q);
      if (push_ok) begin
        wr_ptr_d        = ptr_inc(wr_ptr_q);
        wr_en[wr_ptr_q] = 1'b1;
      end
      count_d = count_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      count_q  <= count_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i) begin
      if (wr_en[g]) mem_q[g] <= push_data_i;
    end
  end

  assign head_data_o = mem_q[rd_ptr_q];
  assign pop_ok_o    = pop_ok;
  assign underrun_o  = !flush_i && pop_req_i && empty;
  assign count_o     = count_q;
endmodule

// File: rtl/iqs_report.sv
module iqs_report #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pop_ok_i,
  input  logic              pop_first_i,
  input  logic [DATA_W-1:0] head_data_i,
  input  logic              underrun_i,
  output logic              rm_valid_o,
  output logic              rm_first_o,
  output logic [DATA_W-1:0] rm_byte_o,
  output logic              err_o
);
  logic              valid_d, first_d, err_d, byte_en;
  logic [DATA_W-1:0] byte_q;
  logic              valid_q, first_q, err_q;

  always_comb begin
    valid_d = pop_ok_i;
    first_d = pop_ok_i && pop_first_i;
    byte_en = pop_ok_i;
    err_d   = err_q || underrun_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      first_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      first_q <= first_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) byte_q <= '0;
    else if (byte_en) byte_q <= head_data_i;
  end

  assign rm_valid_o = valid_q;
  assign rm_first_o = first_q;
  assign rm_byte_o  = byte_q;
  assign err_o      = err_q;
endmodule

// File: rtl/iq_shadow_tracker.sv
module iq_shadow_tracker #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        bus_stat_i,
  input  logic              fetch_stb_i,
  input  logic [DATA_W-1:0] fetch_data_i,
  input  logic [1:0]        qstat_i,
  output logic              rm_valid_o,
  output logic              rm_first_o,
  output logic [DATA_W-1:0] rm_byte_o,
  output logic [CNT_W-1:0]  fill_o,
  output logic              underrun_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic              push_req, pop_req, pop_first, flush;
  logic              pop_ok, underrun;
  logic [DATA_W-1:0] head_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  iqs_decode i_decode (
    .bus_stat_i  (bus_stat_i),
    .fetch_stb_i (fetch_stb_i),
    .qstat_i     (qstat_i),
    .push_req_o  (push_req),
    .pop_req_o   (pop_req),
    .pop_first_o (pop_first),
    .flush_o     (flush)
  );

  iqs_shadow_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .push_req_i  (push_req),
    .push_data_i (fetch_data_i),
    .pop_req_i   (pop_req),
    .flush_i     (flush),
    .head_data_o (head_data),
    .pop_ok_o    (pop_ok),
    .underrun_o  (underrun),
    .count_o     (fill_o)
  );

  iqs_report #(.DATA_W(DATA_W)) i_report (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .pop_ok_i    (pop_ok),
    .pop_first_i (pop_first),
    .head_data_i (head_data),
    .underrun_i  (underrun),
    .rm_valid_o  (rm_valid_o),
    .rm_first_o  (rm_first_o),
    .rm_byte_o   (rm_byte_o),
    .err_o       (underrun_o)
  );
endmodule

// File: rtl/iqs_checker.sv
module iqs_checker #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       bus_stat_i,
  input logic             fetch_stb_i,
  input logic [1:0]       qstat_i,
  input logic             rm_valid_o,
  input logic             rm_first_o,
  input logic [CNT_W-1:0] fill_o,
  input logic             underrun_o
);
  logic fetch_seen;
  assign fetch_seen = fetch_stb_i && (bus_stat_i == 3'b100);

  p_fill_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(fill_o) <= DEPTH);

  p_flush_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qstat_i == 2'b10) |=> (fill_o == '0) && !rm_valid_o);

  p_pop_report_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qstat_i[0] && fill_o != '0) |=> rm_valid_o && (rm_first_o == $past(qstat_i == 2'b01)));

  p_first_needs_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rm_first_o |-> rm_valid_o);

  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qstat_i == 2'b00 && !fetch_seen) |=> !rm_valid_o && $stable(fill_o));

  p_swap_level_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qstat_i[0] && fill_o != '0 && fetch_seen) |=> $stable(fill_o));

  p_underrun_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qstat_i[0] && fill_o == '0) |=> underrun_o && !rm_valid_o);

  p_underrun_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> underrun_o);

  p_full_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qstat_i == 2'b00 && int'(fill_o) == DEPTH) |=> int'(fill_o) == DEPTH);
endmodule

bind iq_shadow_tracker iqs_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_sync_n),
  .bus_stat_i  (bus_stat_i),
  .fetch_stb_i (fetch_stb_i),
  .qstat_i     (qstat_i),
  .rm_valid_o  (rm_valid_o),
  .rm_first_o  (rm_first_o),
  .fill_o      (fill_o),
  .underrun_o  (underrun_o)
);

// File: tb/test_iq_shadow_tracker.sv
`timescale 1ns/1ps
module test_iq_shadow_tracker;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [2:0] bus_stat_i;
  logic       fetch_stb_i;
  logic [7:0] fetch_data_i;
  logic [1:0] qstat_i;
  logic       rm_valid_o, rm_first_o, underrun_o;
  logic [7:0] rm_byte_o;
  logic [2:0] fill_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk_i = ~clk_i;

  iq_shadow_tracker i_iq_shadow_tracker (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_stat_i(bus_stat_i),
    .fetch_stb_i(fetch_stb_i), .fetch_data_i(fetch_data_i), .qstat_i(qstat_i),
    .rm_valid_o(rm_valid_o), .rm_first_o(rm_first_o), .rm_byte_o(rm_byte_o),
    .fill_o(fill_o), .underrun_o(underrun_o)
  );

  // Vector: req[31:28] stb[27] bus[26:24] data[23:16] qs[15:14]
  //         exp valid[13] first[12] byte[11:4] fill[3:1] err[0]
  localparam int NV = 22;
  localparam logic [31:0] VEC [NV] = '{
    {4'd2, 1'b1, 3'd4, 8'hA1, 2'b00, 1'b0, 1'b0, 8'h00, 3'd1, 1'b0}, // R2 fetch
    {4'd2, 1'b1, 3'd4, 8'hB2, 2'b00, 1'b0, 1'b0, 8'h00, 3'd2, 1'b0}, // R2 fetch
    {4'd2, 1'b1, 3'd5, 8'hC3, 2'b00, 1'b0, 1'b0, 8'h00, 3'd2, 1'b0}, // R2 wrong code
    {4'd2, 1'b0, 3'd4, 8'hD4, 2'b00, 1'b0, 1'b0, 8'h00, 3'd2, 1'b0}, // R2 no strobe
    {4'd3, 1'b0, 3'd7, 8'h00, 2'b01, 1'b1, 1'b1, 8'hA1, 3'd1, 1'b0}, // R3 first
    {4'd7, 1'b1, 3'd4, 8'hC3, 2'b11, 1'b1, 1'b0, 8'hB2, 3'd1, 1'b0}, // R7 swap
    {4'd6, 1'b0, 3'd7, 8'h00, 2'b00, 1'b0, 1'b0, 8'hB2, 3'd1, 1'b0}, // R6 idle
    {4'd4, 1'b1, 3'd4, 8'hD4, 2'b00, 1'b0, 1'b0, 8'hB2, 3'd2, 1'b0}, // R4
    {4'd4, 1'b1, 3'd4, 8'hE5, 2'b00, 1'b0, 1'b0, 8'hB2, 3'd3, 1'b0}, // R4
    {4'd4, 1'b1, 3'd4, 8'hF6, 2'b00, 1'b0, 1'b0, 8'hB2, 3'd4, 1'b0}, // R4 full
    {4'd9, 1'b1, 3'd4, 8'h77, 2'b00, 1'b0, 1'b0, 8'hB2, 3'd4, 1'b0}, // R9 drop
    {4'd7, 1'b1, 3'd4, 8'h88, 2'b11, 1'b1, 1'b0, 8'hC3, 3'd4, 1'b0}, // R7 swap at full
    {4'd3, 1'b0, 3'd7, 8'h00, 2'b01, 1'b1, 1'b1, 8'hD4, 3'd3, 1'b0}, // R3
    {4'd4, 1'b0, 3'd7, 8'h00, 2'b11, 1'b1, 1'b0, 8'hE5, 3'd2, 1'b0}, // R4
    {4'd4, 1'b0, 3'd7, 8'h00, 2'b11, 1'b1, 1'b0, 8'hF6, 3'd1, 1'b0}, // R4
    {4'd9, 1'b0, 3'd7, 8'h00, 2'b11, 1'b1, 1'b0, 8'h88, 3'd0, 1'b0}, // R9 77 gone
    {4'd2, 1'b1, 3'd4, 8'h11, 2'b00, 1'b0, 1'b0, 8'h88, 3'd1, 1'b0}, // R2
    {4'd5, 1'b1, 3'd4, 8'h22, 2'b10, 1'b0, 1'b0, 8'h88, 3'd0, 1'b0}, // R5 flush
    {4'd8, 1'b0, 3'd7, 8'h00, 2'b01, 1'b0, 1'b0, 8'h88, 3'd0, 1'b1}, // R8 underrun
    {4'd8, 1'b1, 3'd4, 8'h33, 2'b11, 1'b0, 1'b0, 8'h88, 3'd1, 1'b1}, // R8 push kept
    {4'd8, 1'b0, 3'd7, 8'h00, 2'b01, 1'b1, 1'b1, 8'h33, 3'd0, 1'b1}, // R8 sticky
    {4'd6, 1'b0, 3'd7, 8'h00, 2'b00, 1'b0, 1'b0, 8'h33, 3'd0, 1'b1}  // R6
  };

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
      4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
      4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [13:0] observed();
    return {rm_valid_o, rm_first_o, rm_byte_o, fill_o, underrun_o};
  endfunction

  task automatic check(input string req, input logic [13:0] exp);
    n_chk++;
    if (observed() !== exp) begin
      n_bad++;
      $display("FAIL %s: got v/f/byte/fill/err=%0b/%0b/%02h/%0d/%0b expected %0b/%0b/%02h/%0d/%0b",
               req, observed()[13], observed()[12], observed()[11:4], observed()[3:1], observed()[0],
               exp[13], exp[12], exp[11:4], exp[3:1], exp[0]);
    end
  endtask

  task automatic idle_inputs();
    fetch_stb_i = 1'b0; bus_stat_i = 3'd7; fetch_data_i = 8'h00; qstat_i = 2'b00;
  endtask

  initial begin
    rst_ni = 1'b0;
    idle_inputs();
    repeat (3) @(posedge clk_i);
    #1 check("R1", 14'd0);                       // R1 reset state
    @(negedge clk_i) rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      fetch_stb_i  = VEC[i][27];
      bus_stat_i   = VEC[i][26:24];
      fetch_data_i = VEC[i][23:16];
      qstat_i      = VEC[i][15:14];
      @(posedge clk_i);
      #1 check(req_name(VEC[i][31:28]), VEC[i][13:0]);
      @(negedge clk_i);
    end
    idle_inputs();

    // R1: reset in mid-run clears the sticky flag and the last byte
    @(negedge clk_i) rst_ni = 1'b0;
    #1 check("R1", 14'd0);
    @(negedge clk_i) rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1", 14'd0);

    // R3: normal operation after reset, first-byte removal of 5A
    fetch_stb_i = 1'b1; bus_stat_i = 3'd4; fetch_data_i = 8'h5A;
    @(posedge clk_i); #1 check("R2", {1'b0, 1'b0, 8'h00, 3'd1, 1'b0});
    @(negedge clk_i) idle_inputs(); qstat_i = 2'b01;
    @(posedge clk_i); #1 check("R3", {1'b1, 1'b1, 8'h5A, 3'd0, 1'b0});
    @(negedge clk_i) idle_inputs();
    @(posedge clk_i); #1 check("R6", {1'b0, 1'b0, 8'h5A, 3'd0, 1'b0});

    // R10: four fetches then a fifth without removal stays at depth 4
    for (int k = 0; k < 5; k++) begin
      @(negedge clk_i);
      fetch_stb_i = 1'b1; bus_stat_i = 3'd4; fetch_data_i = 8'(8'h60 + k);
    end
    @(posedge clk_i); #1 check("R10", {1'b0, 1'b0, 8'h5A, 3'd4, 1'b0});
    @(negedge clk_i) idle_inputs(); qstat_i = 2'b10;
    @(posedge clk_i); #1 check("R5", {1'b0, 1'b0, 8'h5A, 3'd0, 1'b0});
    @(negedge clk_i) idle_inputs();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule